// File: doc/BRIEF.md
# Self-Test Result Threshold Checker

This block watches the results that a converter's built-in self-test sequence produces and compares each one against a pair of limits chosen by the algorithm and the step it belongs to. Three algorithms are monitored: a supply algorithm (S, steps 0 to 2), a resistive-network algorithm (RC, steps 0 to 18) and a capacitive-network algorithm (C, steps 0 to 16). Step 1 of the supply algorithm delivers an integer part and a fraction part instead of a single value. It is judged by a two-level compare: the integer part is checked first, and the fraction is consulted only when the integer part sits exactly on one of its limits.

Seven limit registers are loaded through a simple write port, each write carrying one high limit and one low limit. When a check fails and the watchdog of that algorithm is enabled, the sticky fail flag of the algorithm is set. The OR of the three flags drives a fault line toward a chip-level fault collector. Software clears the flags by writing ones.

Top module: `adc_st_limit_check`

## Requirements
- R1: After reset all three fail flags and the fault line are 0. Every limit register holds high = all ones and low = 0, so that no result fails until limits are written.
- R2: A write with cfg_we=1 loads the register chosen by cfg_sel (0 = S step 0, 1 = S1 integer, 2 = S1 fraction, 3 = S step 2, 4 = all RC steps, 5 = C step 0, 6 = C steps 1 to 16). The high limit comes from cfg_wdata[16+DW-1:16] and the low limit from cfg_wdata[DW-1:0]. All other data bits are ignored, and cfg_sel = 7 changes no register.
- R3: A single-value result (S steps 0 and 2, every RC step, every C step) passes when low ≤ result ≤ high. The limits come from the register that R2 maps to the step, and C step 0 uses a different register from C steps 1 to 16.
- R4: For S step 1, an integer part above the integer high limit or below the integer low limit fails.
- R5: For S step 1, an integer part equal to the integer high limit fails if the fraction is above the fraction high limit. An integer part equal to the integer low limit fails if the fraction is below the fraction low limit. When both integer limits are equal, both fraction bounds apply at once. An integer part strictly between the limits passes.
- R6: wd_en bit 0 (S), bit 1 (RC) and bit 2 (C) enable the watchdogs. A failing result of an algorithm whose bit is 0 sets no flag.
- R7: fail_flags bit 0 (S), bit 1 (RC) and bit 2 (C) are sticky. A cycle with clr_we=1 clears the bits that are set in clr_mask. A failure that occurs in the same cycle as a clear of its bit leaves the bit set.
- R8: A failure presented with res_valid high at one rising edge is visible on fail_flags and fault_out right after that edge, and not before it. fault_out is 1 exactly when any fail flag is 1.
- R9: A result with res_alg = 3, or with a step beyond the last step of its algorithm (S ≥ 3, RC ≥ 19, C ≥ 17), sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_sel | input | 3 | Limit register select |
| cfg_wdata | input | 32 | Limit write data (high and low fields) |
| wd_en | input | 3 | Watchdog enables: S, RC, C |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 3 | Write-1-to-clear mask for the fail flags |
| res_valid | input | 1 | Result valid strobe |
| res_alg | input | 2 | Algorithm: 0 = S, 1 = RC, 2 = C |
| res_step | input | 5 | Step number within the algorithm |
| res_data | input | DW | Single-value result |
| res_int | input | DW | S step 1 integer part |
| res_frac | input | DW | S step 1 fraction part |
| fail_flags | output | 3 | Sticky fail flags: S, RC, C |
| fault_out | output | 1 | Fault line to the fault collector |

## Verification
The hardest behaviour to reach is the S step 1 boundary logic, and the equal-integer-limits case in particular, where both fraction bounds must act on the same result. The bench uses a 4-bit data width so that it can sweep every integer part and every fraction against a grid of integer limit pairs, including the pairs whose two limits are equal. It compares each outcome with a model computed from the tie rules. The set-versus-clear collision in the flag register is reached by presenting a failing result in the same cycle as a clear of the same bit.

// File: rtl/adc_st_limit_check.sv
module adc_st_limit_check #(
  parameter int DW       = 12,
  parameter int S_STEPS  = 3,
  parameter int RC_STEPS = 19,
  parameter int C_STEPS  = 17,
  parameter int SW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic [2:0]    wd_en,
  input  logic          clr_we,
  input  logic [2:0]    clr_mask,
  input  logic          res_valid,
  input  logic [1:0]    res_alg,
  input  logic [SW-1:0] res_step,
  input  logic [DW-1:0] res_data,
  input  logic [DW-1:0] res_int,
  input  logic [DW-1:0] res_frac,
  output logic [2:0]    fail_flags,
  output logic          fault_out
);
  localparam int NREG   = 7;
  localparam int HI_LSB = 16;
  localparam logic [2:0] R_S0 = 3'd0, R_S1I = 3'd1, R_S1F = 3'd2, R_S2 = 3'd3,
                         R_RC = 3'd4, R_C0 = 3'd5, R_CN = 3'd6;

  logic [DW-1:0] hi_q [NREG];
  logic [DW-1:0] lo_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= '1;
        lo_q[g] <= '0;
      end else if (cfg_we && cfg_sel == 3'(g)) begin
        hi_q[g] <= cfg_wdata[HI_LSB +: DW];
        lo_q[g] <= cfg_wdata[DW-1:0];
      end
    end
  end

  logic [2:0] idx;
  logic       step_ok;
  always_comb begin
    idx     = R_S0;
    step_ok = 1'b0;
    case (res_alg)
      2'd0: begin
        step_ok = res_step < SW'(S_STEPS);
        idx     = (res_step == SW'(2)) ? R_S2 : R_S0;
      end
      2'd1: begin
        step_ok = res_step < SW'(RC_STEPS);
        idx     = R_RC;
      end
      2'd2: begin
        step_ok = res_step < SW'(C_STEPS);
        idx     = (res_step == '0) ? R_C0 : R_CN;
      end
      default: ;
    endcase
  end

  wire is_s1 = (res_alg == 2'd0) && (res_step == SW'(1));

  wire single_bad = (res_data > hi_q[idx]) || (res_data < lo_q[idx]);

  wire s1_bad = (res_int > hi_q[R_S1I]) || (res_int < lo_q[R_S1I]) ||
                ((res_int == hi_q[R_S1I]) && (res_frac > hi_q[R_S1F])) ||
                ((res_int == lo_q[R_S1I]) && (res_frac < lo_q[R_S1F]));

  wire viol = res_valid && step_ok && (is_s1 ? s1_bad : single_bad);

  logic [2:0] hit;
  always_comb begin
    hit = '0;
    if (viol) begin
      case (res_alg)
        2'd0:    hit[0] = wd_en[0];
        2'd1:    hit[1] = wd_en[1];
        2'd2:    hit[2] = wd_en[2];
        default: ;
      endcase
    end
  end

  wire [2:0] clr_bits = clr_we ? clr_mask : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_flags <= '0;
    else        fail_flags <= (fail_flags & ~clr_bits) | hit;
  end

  assign fault_out = |fail_flags;

  // R8: a flag only rises after a result was presented
  assert_rise_needs_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail_flags & ~$past(fail_flags)) != 3'b000) |-> $past(res_valid));

  // R7: a flag only falls after a clear write
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(fail_flags) & ~fail_flags) != 3'b000) |-> $past(clr_we));

  // R6: disabled watchdogs raise nothing
  assert_s_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_alg == 2'd0 && !wd_en[0]) |=> !$rose(fail_flags[0]));
  assert_rc_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_alg == 2'd1 && !wd_en[1]) |=> !$rose(fail_flags[1]));
  assert_c_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_alg == 2'd2 && !wd_en[2]) |=> !$rose(fail_flags[2]));

  // R9: an unknown algorithm leaves the flags alone
  assert_bad_alg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_alg == 2'd3 && !clr_we) |=> (fail_flags == $past(fail_flags)));

endmodule

// File: tb/adc_st_limit_check_tb.sv
module adc_st_limit_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [2:0]    wd_en = 3'b111;
  logic          clr_we = 1'b0;
  logic [2:0]    clr_mask = '0;
  logic          res_valid = 1'b0;
  logic [1:0]    res_alg = '0;
  logic [SW-1:0] res_step = '0;
  logic [DW-1:0] res_data = '0, res_int = '0, res_frac = '0;
  logic [2:0]    fail_flags;
  logic          fault_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_st_limit_check #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .wd_en(wd_en), .clr_we(clr_we), .clr_mask(clr_mask), .res_valid(res_valid),
    .res_alg(res_alg), .res_step(res_step), .res_data(res_data), .res_int(res_int),
    .res_frac(res_frac), .fail_flags(fail_flags), .fault_out(fault_out));

  task automatic expect_eq(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input int hi, input int lo);
    logic [31:0] w;
    w = 32'hFFF5_AAA0;
    w[19:16] = 4'(hi);
    w[3:0] = 4'(lo);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_all();
    clr_we = 1; clr_mask = 3'b111;
    @(negedge clk);
    clr_we = 0; clr_mask = 0;
  endtask

  task automatic run(input int alg, input int step, input int d, input int i, input int f,
                     input logic [2:0] exp, input string req);
    @(negedge clk);
    res_valid = 1; res_alg = 2'(alg); res_step = SW'(step);
    res_data = DW'(d); res_int = DW'(i); res_frac = DW'(f);
    @(negedge clk);
    res_valid = 0;
    expect_eq(int'(fail_flags), int'(exp), req);
    expect_eq(int'(fault_out), int'(exp != 0), req);
    clear_all();
  endtask

  function automatic bit s1_fail(int i, int f, int ilo, int ihi, int flo, int fhi);
    if (i > ihi || i < ilo) return 1;
    if (i == ihi && f > fhi) return 1;
    if (i == ilo && f < flo) return 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lims[5] = '{0, 3, 7, 12, 15};
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_eq(int'(fail_flags), 0, "R1");
    expect_eq(int'(fault_out), 0, "R1");
    rst_n = 1;
    @(negedge clk);
    // R1: default limits pass extremes
    run(0, 0, 15, 0, 0, 3'b000, "R1");
    run(2, 5, 0, 0, 0, 3'b000, "R1");
    run(0, 1, 0, 0, 0, 3'b000, "R1");

    // R3 / R2: sweep single-value registers with junk in unused bits
    for (int r = 0; r < 5; r++) begin
      int alg, sel;
      alg = (r < 2) ? 0 : (r == 2) ? 1 : 2;
      sel = (r == 0) ? 0 : (r == 1) ? 3 : (r == 2) ? 4 : (r == 3) ? 5 : 6;
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++) begin
          wr(3'(sel), lims[b], lims[a]);
          for (int v = 0; v < 16; v++) begin
            int step;
            logic [2:0] e;
            step = (r == 0) ? 0 : (r == 1) ? 2 : (r == 2) ? (v + a) % 19 :
                   (r == 3) ? 0 : 1 + (v + b) % 16;
            e = '0;
            if (v < lims[a] || v > lims[b]) e[alg] = 1'b1;
            run(alg, step, v, 0, 0, e, "R3");
          end
        end
      wr(3'(sel), 15, 0);
    end

    // R3: C0 limits do not reach C steps 1..16
    wr(3'd5, 6, 4);
    run(2, 3, 14, 0, 0, 3'b000, "R3");
    run(2, 0, 14, 0, 0, 3'b100, "R3");
    wr(3'd5, 15, 0);

    // R2: select 7 writes nothing
    wr(3'd0, 9, 2);
    wr(3'd7, 1, 1);
    run(0, 0, 9, 0, 0, 3'b000, "R2");
    run(0, 0, 10, 0, 0, 3'b001, "R2");
    wr(3'd0, 15, 0);

    // R4 / R5: S step 1 sweep, equal integer limits included
    wr(3'd2, 10, 5);
    for (int ilo = 0; ilo < 16; ilo += 3)
      for (int ihi = ilo; ihi < 16; ihi += 3) begin
        wr(3'd1, ihi, ilo);
        for (int i = 0; i < 16; i++)
          for (int f = 0; f < 16; f++) begin
            logic [2:0] e;
            e = {2'b00, s1_fail(i, f, ilo, ihi, 5, 10)};
            if (i > ihi || i < ilo) run(0, 1, 0, i, f, e, "R4");
            else run(0, 1, 0, i, f, e, "R5");
          end
      end
    wr(3'd1, 7, 7);
    run(0, 1, 0, 7, 5, 3'b000, "R5");
    run(0, 1, 0, 7, 10, 3'b000, "R5");
    run(0, 1, 0, 7, 4, 3'b001, "R5");
    run(0, 1, 0, 7, 11, 3'b001, "R5");
    wr(3'd1, 15, 0);
    wr(3'd2, 15, 0);

    // R6: disabled watchdogs
    wr(3'd4, 8, 4);
    wd_en = 3'b101;
    run(1, 2, 12, 0, 0, 3'b000, "R6");
    wd_en = 3'b111;
    run(1, 2, 12, 0, 0, 3'b010, "R6");

    // R9: out-of-range steps and unknown algorithm
    wr(3'd0, 8, 4); wr(3'd3, 8, 4); wr(3'd6, 8, 4);
    run(0, 3, 12, 0, 0, 3'b000, "R9");
    run(1, 19, 12, 0, 0, 3'b000, "R9");
    run(2, 17, 12, 0, 0, 3'b000, "R9");
    run(3, 0, 12, 0, 0, 3'b000, "R9");
    run(1, 18, 12, 0, 0, 3'b010, "R9");
    run(2, 16, 12, 0, 0, 3'b100, "R9");

    // R8: timing of the flag and fault line
    @(negedge clk);
    res_valid = 1; res_alg = 0; res_step = 0; res_data = 13;
    #1;
    expect_eq(int'(fault_out), 0, "R8");
    @(posedge clk); #1;
    res_valid = 0;
    expect_eq(int'(fault_out), 1, "R8");
    expect_eq(int'(fail_flags), 1, "R8");

    // R7: sticky, partial clear, set wins over clear
    @(negedge clk);
    res_valid = 1; res_alg = 1; res_step = 0; res_data = 13;
    @(negedge clk);
    res_valid = 0;
    repeat (3) @(negedge clk);
    expect_eq(int'(fail_flags), 3, "R7");
    clr_we = 1; clr_mask = 3'b001;
    @(negedge clk);
    clr_we = 0; clr_mask = 0;
    expect_eq(int'(fail_flags), 2, "R7");
    res_valid = 1; res_alg = 2; res_step = 4; res_data = 13;
    clr_we = 1; clr_mask = 3'b110;
    @(negedge clk);
    res_valid = 0; clr_we = 0; clr_mask = 0;
    expect_eq(int'(fail_flags), 4, "R7");
    expect_eq(int'(fault_out), 1, "R8");
    clear_all();
    expect_eq(int'(fault_out), 0, "R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule